// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Interface

This block links a display controller's register file and display memory to an external microprocessor over a shared parallel bus. Three mode pins set how it works. One pin chooses parallel or serial operation. A second pin chooses the bus protocol: either two active-low strobes, one for read and one for write, or an enable strobe together with a read/write level. A third pin sets the data width to 8 or 16 bits. Two select pins of opposite polarity gate all activity. While the chip is deselected, the block holds a clear line high towards the serial shifter.

Every control and data pin passes through a synchroniser into the internal clock domain. The block decodes each bus cycle into exactly one of four single-cycle internal pulses: display write, display read, instruction write, or status read. The display/register line picks between the display path and the register path. A register access uses only the low byte of the bus. On reads, the block drives the bus through a registered per-line output enable. When no read is in progress, every line is released.

Top module: `hostbus_if`

## Requirements
- R1: The chip counts as selected only when `csel_n_i`=0 and `csel_i`=1. For the other three combinations, no operation pulse is raised and `bus_oe_o` stays 0, whatever the strobes do.
- R2: `ser_clr_o` is 1 while the chip is deselected and 0 while it is selected. It follows the select pins after SYNC+1 clock cycles and does not depend on `par_mode_i`.
- R3: With `par_mode_i`=0 (serial), the parallel decoder stays idle: no operation pulse, and `bus_oe_o` stays 0.
- R4: With `proto_i`=0, `strb_a_i` is an active-low read strobe and `strb_b_i` is an active-low write strobe. A read is a=0,b=1. A write is a=1,b=0.
- R5: With `proto_i`=1, `strb_a_i` is an active-high enable and `strb_b_i` is a direction level. While enable is 1, a level of 1 is a read and 0 is a write.
- R6: With `dsel_i`=1, a write gives `disp_wr_o` and a read gives `disp_rd_o`. With `dsel_i`=0, a write gives `cmd_wr_o` and a read gives `stat_rd_o`.
- R7: Each access raises exactly one single-cycle pulse, and at most one pulse is high at any time. A write pulse appears SYNC+1 cycles after the write strobe is released (strobe-pair) or the enable falls (enable protocol). A read pulse appears SYNC+1 cycles after the read becomes active.
- R8: `wr_data_o` takes the bus value held during the write. All 16 bits are kept for a display write with `wide_i`=1. In every other case, bits [15:8] are 0.
- R9: While a read is active, `bus_oe_o[7:0]` is 8'hFF. `bus_oe_o[15:8]` is 8'hFF only for a display read with `wide_i`=1. `bus_out_o` carries the display word (upper byte zeroed when narrow) or the status byte in [7:0]. When no read is active, `bus_oe_o` is 0.
- R10: With `proto_i`=0, both strobes low together form an invalid cycle. No operation is issued and the bus is not driven.
- R11: After synchronous reset, all pulses are 0, `bus_oe_o` is 0, `wr_data_o` is 0 and `ser_clr_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| csel_n_i | input | 1 | Active-low chip select |
| csel_i | input | 1 | Active-high chip select |
| par_mode_i | input | 1 | 1 = parallel, 0 = serial |
| proto_i | input | 1 | 0 = strobe pair, 1 = enable + direction |
| wide_i | input | 1 | 0 = 8-bit bus, 1 = 16-bit bus |
| dsel_i | input | 1 | 1 = display data, 0 = register |
| strb_a_i | input | 1 | Read strobe (active low) or enable (active high) |
| strb_b_i | input | 1 | Write strobe (active low) or direction level |
| bus_in_i | input | DW | Data bus input |
| bus_out_o | output | DW | Data bus drive value |
| bus_oe_o | output | DW | Per-line output enable |
| ser_clr_o | output | 1 | Clear for serial shift register and bit counter |
| disp_wr_o | output | 1 | Display write pulse |
| disp_rd_o | output | 1 | Display read pulse |
| cmd_wr_o | output | 1 | Instruction write pulse |
| stat_rd_o | output | 1 | Status read pulse |
| wr_data_o | output | DW | Captured write data |
| disp_rd_data_i | input | DW | Display word to return on reads |
| stat_data_i | input | RW | Status byte to return on reads |

## Verification
The hardest case to reach is the write that completes on the release edge. The pulse is due SYNC+1 cycles after the strobe lets go, not when it first asserts. The data it must carry is the value held before the release. The bench stamps the cycle of every pulse and compares it with the cycle of the release. It sweeps both protocols, both widths, both data paths and several data words. It also forces both strobes low together, every deselect combination and serial mode, to show that these produce no pulse and leave the bus undriven.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef struct packed {
    logic csel_n;
    logic csel;
    logic par;
    logic proto;
    logic wide;
    logic dsel;
    logic strb_a;
    logic strb_b;
  } ctl_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
  import hbi_pkg::*;
(
  input  ctl_t c,
  output logic chip_on,
  output logic rd_act,
  output logic wr_act,
  output logic wr_held
);
  logic live;

  always_comb begin
    chip_on = ~c.csel_n & c.csel;
    live    = chip_on & c.par;
    if (c.proto) begin
      rd_act  = live & c.strb_a & c.strb_b;
      wr_act  = live & c.strb_a & ~c.strb_b;
      wr_held = c.strb_a;
    end else begin
      rd_act  = live & ~c.strb_a & c.strb_b;
      wr_act  = live & c.strb_a & ~c.strb_b;
      wr_held = ~c.strb_b;
    end
  end
endmodule

// File: rtl/hbi_rdpath.sv
module hbi_rdpath #(
  parameter int DW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act,
  input  logic          dsel,
  input  logic          wide,
  input  logic [DW-1:0] disp_data,
  input  logic [RW-1:0] stat_data,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] bus_oe
);
  localparam int HW = DW - RW;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= '0;
    end else if (rd_act) begin
      bus_oe <= {{HW{dsel & wide}}, {RW{1'b1}}};
      if (dsel && wide) bus_out <= disp_data;
      else if (dsel)    bus_out <= {{HW{1'b0}}, disp_data[RW-1:0]};
      else              bus_out <= {{HW{1'b0}}, stat_data};
    end else begin
      bus_out <= '0;
      bus_oe  <= '0;
    end
  end
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
  import hbi_pkg::*;
#(
  parameter int DW   = 16,
  parameter int RW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csel_n_i,
  input  logic          csel_i,
  input  logic          par_mode_i,
  input  logic          proto_i,
  input  logic          wide_i,
  input  logic          dsel_i,
  input  logic          strb_a_i,
  input  logic          strb_b_i,
  input  logic [DW-1:0] bus_in_i,
  output logic [DW-1:0] bus_out_o,
  output logic [DW-1:0] bus_oe_o,
  output logic          ser_clr_o,
  output logic          disp_wr_o,
  output logic          disp_rd_o,
  output logic          cmd_wr_o,
  output logic          stat_rd_o,
  output logic [DW-1:0] wr_data_o,
  input  logic [DW-1:0] disp_rd_data_i,
  input  logic [RW-1:0] stat_data_i
);
  localparam int CW = $bits(ctl_t);
  localparam int VW = CW + DW;
  localparam int HW = DW - RW;

  ctl_t          raw_c, c;
  logic [VW-1:0] raw, smp;
  logic [DW-1:0] d;

  assign raw_c = '{csel_n: csel_n_i, csel: csel_i, par: par_mode_i,
                   proto: proto_i, wide: wide_i, dsel: dsel_i,
                   strb_a: strb_a_i, strb_b: strb_b_i};
  assign raw = {raw_c, bus_in_i};

  hbi_sync #(.W(VW), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(smp)
  );

  assign c = smp[VW-1:DW];
  assign d = smp[DW-1:0];

  logic chip_on, rd_act, wr_act, wr_held;

  hbi_decode u_dec (
    .c(c), .chip_on(chip_on), .rd_act(rd_act),
    .wr_act(wr_act), .wr_held(wr_held)
  );

  logic          rd_q, wr_q, dsel_q, wide_q;
  logic [DW-1:0] data_q;
  logic          rd_start, wr_done;

  assign rd_start = rd_act & ~rd_q & ~wr_q;
  assign wr_done  = wr_q & chip_on & c.par & ~wr_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      dsel_q    <= 1'b0;
      wide_q    <= 1'b0;
      data_q    <= '0;
      disp_wr_o <= 1'b0;
      disp_rd_o <= 1'b0;
      cmd_wr_o  <= 1'b0;
      stat_rd_o <= 1'b0;
      wr_data_o <= '0;
      ser_clr_o <= 1'b1;
    end else begin
      rd_q      <= rd_act;
      wr_q      <= wr_act;
      dsel_q    <= c.dsel;
      wide_q    <= c.wide;
      data_q    <= d;
      disp_rd_o <= rd_start & c.dsel;
      stat_rd_o <= rd_start & ~c.dsel;
      disp_wr_o <= wr_done & dsel_q;
      cmd_wr_o  <= wr_done & ~dsel_q;
      ser_clr_o <= ~chip_on;
      if (wr_done) begin
        if (dsel_q && wide_q) wr_data_o <= data_q;
        else                  wr_data_o <= {{HW{1'b0}}, data_q[RW-1:0]};
      end
    end
  end

  hbi_rdpath #(.DW(DW), .RW(RW)) u_rd (
    .clk(clk), .rst(rst), .rd_act(rd_act), .dsel(c.dsel), .wide(c.wide),
    .disp_data(disp_rd_data_i), .stat_data(stat_data_i),
    .bus_out(bus_out_o), .bus_oe(bus_oe_o)
  );
endmodule

// File: rtl/hbi_chk.sv
module hbi_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ser_clr,
  input logic          disp_wr,
  input logic          disp_rd,
  input logic          cmd_wr,
  input logic          stat_rd,
  input logic [DW-1:0] bus_oe
);
  logic [3:0] ops;
  assign ops = {disp_wr, disp_rd, cmd_wr, stat_rd};

  p_onehot_ops_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ops));

  p_wr_single_r7: assert property (@(posedge clk) disable iff (rst)
    (disp_wr || cmd_wr) |=> !(disp_wr || cmd_wr));

  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    ser_clr |-> (ops == 4'b0 && bus_oe == '0));

  p_upper_needs_lower_r9: assert property (@(posedge clk) disable iff (rst)
    (|bus_oe[DW-1:8]) |-> (&bus_oe[7:0]));

  p_rd_pulse_driven_r9: assert property (@(posedge clk) disable iff (rst)
    (disp_rd || stat_rd) |-> bus_oe[0]);
endmodule

bind hostbus_if hbi_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ser_clr(ser_clr_o),
  .disp_wr(disp_wr_o), .disp_rd(disp_rd_o), .cmd_wr(cmd_wr_o),
  .stat_rd(stat_rd_o), .bus_oe(bus_oe_o)
);

// File: tb/hostbus_if_test.sv
`timescale 1ns/1ps
module hostbus_if_test;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 0, rst = 1;
  logic csel_n, csel, par, proto, wide, dsel, sa, sb;
  logic [15:0] bin, bout, boe, wdat, drd;
  logic [7:0]  sdat;
  logic ser_clr, dwr, drdp, cwr, srd;

  always #2 clk = ~clk;

  hostbus_if #(.DW(16), .RW(8), .SYNC(SYNC)) uut (
    .clk(clk), .rst(rst), .csel_n_i(csel_n), .csel_i(csel),
    .par_mode_i(par), .proto_i(proto), .wide_i(wide), .dsel_i(dsel),
    .strb_a_i(sa), .strb_b_i(sb), .bus_in_i(bin), .bus_out_o(bout),
    .bus_oe_o(boe), .ser_clr_o(ser_clr), .disp_wr_o(dwr), .disp_rd_o(drdp),
    .cmd_wr_o(cwr), .stat_rd_o(srd), .wr_data_o(wdat),
    .disp_rd_data_i(drd), .stat_data_i(sdat)
  );

  int checks = 0, failures = 0;
  int cyc = 0, n_dw = 0, n_dr = 0, n_cw = 0, n_sr = 0, stamp = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1;
    if (dwr)  begin n_dw++; stamp = cyc; end
    if (drdp) begin n_dr++; stamp = cyc; end
    if (cwr)  begin n_cw++; stamp = cyc; end
    if (srd)  begin n_sr++; stamp = cyc; end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_cnt();
    n_dw = 0; n_dr = 0; n_cw = 0; n_sr = 0; stamp = -100;
  endtask

  task automatic idle(bit p);
    sa = p ? 1'b0 : 1'b1;
    sb = 1'b1;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // Write access; ok=1 means a pulse is expected
  task automatic do_write(bit p, bit w, bit ds, logic [15:0] v, bit ok, string req);
    int rel;
    logic [15:0] exp_d;
    @(negedge clk);
    proto = p; wide = w; dsel = ds; bin = v; idle(p);
    wait_n(LAT + 2);
    clr_cnt();
    if (p) begin sb = 0; @(negedge clk); sa = 1; end
    else sb = 0;
    wait_n(4);
    if (p) sa = 0; else sb = 1;
    rel = cyc;
    @(negedge clk); if (p) sb = 1;
    wait_n(LAT + 3);
    if (ok) begin
      exp_d = (ds && w) ? v : {8'h00, v[7:0]};
      chk(n_dw == (ds ? 1 : 0), req, "display write count", n_dw, ds ? 1 : 0);
      chk(n_cw == (ds ? 0 : 1), req, "instruction write count", n_cw, ds ? 0 : 1);
      chk(n_dr + n_sr == 0, req, "no read on write", n_dr + n_sr, 0);
      chk(stamp - rel == LAT, "R7", "write pulse latency", stamp - rel, LAT);
      chk(wdat == exp_d, "R8", "captured write data", wdat, exp_d);
    end else begin
      chk(n_dw + n_cw + n_dr + n_sr == 0, req, "no pulse", n_dw + n_cw + n_dr + n_sr, 0);
    end
  endtask

  task automatic do_read(bit p, bit w, bit ds, logic [15:0] v, bit ok, string req);
    int ast;
    logic [15:0] exp_o, exp_e;
    @(negedge clk);
    proto = p; wide = w; dsel = ds; drd = v; sdat = v[7:0] ^ 8'h3C; idle(p);
    wait_n(LAT + 2);
    clr_cnt();
    if (p) begin sb = 1; sa = 1; end else sa = 0;
    ast = cyc;
    wait_n(LAT + 2);
    exp_o = ds ? (w ? v : {8'h00, v[7:0]}) : {8'h00, sdat};
    exp_e = (ds && w) ? 16'hFFFF : 16'h00FF;
    if (ok) begin
      chk(boe == exp_e, "R9", "output enable during read", boe, exp_e);
      chk(bout == exp_o, "R9", "read drive value", bout, exp_o);
      chk(stamp - ast == LAT, "R7", "read pulse latency", stamp - ast, LAT);
    end else
      chk(boe == 16'h0, req, "no drive", boe, 0);
    idle(p);
    wait_n(LAT + 2);
    chk(boe == 16'h0, "R9", "released after read", boe, 0);
    if (ok) begin
      chk(n_dr == (ds ? 1 : 0), req, "display read count", n_dr, ds ? 1 : 0);
      chk(n_sr == (ds ? 0 : 1), req, "status read count", n_sr, ds ? 0 : 1);
      chk(n_dw + n_cw == 0, req, "no write on read", n_dw + n_cw, 0);
    end else
      chk(n_dw + n_cw + n_dr + n_sr == 0, req, "no pulse", n_dw + n_cw + n_dr + n_sr, 0);
  endtask

  initial begin
    csel_n = 1; csel = 0; par = 1; proto = 0; wide = 0; dsel = 0;
    sa = 1; sb = 1; bin = 0; drd = 0; sdat = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(ser_clr == 1, "R11", "clear in reset", ser_clr, 1);
    chk(boe == 0, "R11", "oe in reset", boe, 0);
    chk({dwr, drdp, cwr, srd} == 0, "R11", "pulses in reset", {dwr, drdp, cwr, srd}, 0);
    chk(wdat == 0, "R11", "write data in reset", wdat, 0);
    rst = 0;
    wait_n(LAT + 1);
    chk(ser_clr == 1, "R2", "clear while deselected", ser_clr, 1);
    csel_n = 0; csel = 1;
    wait_n(LAT);
    chk(ser_clr == 0, "R2", "clear drops when selected", ser_clr, 0);

    // R4 R5 R6 sweep of protocol, width, path and data
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 2; w++)
        for (int ds = 0; ds < 2; ds++)
          for (int k = 0; k < 3; k++) begin
            logic [15:0] v;
            v = 16'hA5C3 ^ 16'(k * 16'h1E69) ^ 16'(p * 16'h0F0F);
            do_write(p[0], w[0], ds[0], v, 1, p ? "R5 R6" : "R4 R6");
            do_read(p[0], w[0], ds[0], ~v, 1, p ? "R5 R6" : "R4 R6");
          end

    // R10 both strobes low
    @(negedge clk); proto = 0; idle(0); wait_n(LAT + 2); clr_cnt();
    sa = 0; sb = 0; wait_n(LAT + 3);
    chk(boe == 0, "R10", "no drive on invalid", boe, 0);
    sa = 1; sb = 1; wait_n(LAT + 3);
    chk(n_dw + n_cw + n_dr + n_sr == 0, "R10", "no op on invalid",
        n_dw + n_cw + n_dr + n_sr, 0);

    // R1 each deselect combination
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      csel_n = (s != 1); csel = (s == 2);
      wait_n(LAT);
      chk(ser_clr == 1, "R2", "clear for deselect combo", ser_clr, 1);
      do_write(s[0], 1, 1, 16'h1234, 0, "R1");
      do_read(s[0], 1, 0, 16'h5678, 0, "R1");
    end

    // R3 serial mode: selected but parallel decoder idle
    @(negedge clk); csel_n = 0; csel = 1; par = 0;
    wait_n(LAT);
    chk(ser_clr == 0, "R2", "clear independent of mode", ser_clr, 0);
    do_write(0, 1, 1, 16'hBEEF, 0, "R3");
    do_read(1, 1, 1, 16'hCAFE, 0, "R3");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule